// File: doc/BRIEF.md
# Broadcast Raster Timing Generator

This block produces the raster timing for a composite-video encoder running from a 14.318 MHz clock, four times the NTSC colour subcarrier. A horizontal counter steps through each line and a vertical counter steps through each frame. Active-video, horizontal-sync and vertical-sync levels, plus start-of-frame and end-of-frame strobes, are decoded from the two counts. The counts go out with the strobes so that a downstream fetch unit can form addresses from them.

A select input picks NTSC or PAL line and frame totals. The select is taken only at the end of a frame, so a frame never mixes the two standards. The `HALF_RATE` parameter halves every horizontal quantity, for use with a divided 7.159 MHz pixel clock. All totals and positions are parameters. The defaults give a 320 by 200 picture at two clocks per pixel.

Top module: `tv_raster_gen`

## Requirements
- R1: While `rstN` is low, `xPos` and `yPos` are 0, `sof` is high and NTSC totals are in force. Reset is asynchronous.
- R2: `xPos` increments by one each clock and wraps to 0 after the last count. There are 910 counts per line in NTSC and 916 in PAL (nearest to 64 us) at the default rate.
- R3: `yPos` changes only when `xPos` wraps. It counts 263 lines per frame in NTSC and 312 in PAL.
- R4: `active` is high exactly when `xPos` is below the active width (640 clocks, so 320 pixels) and `yPos` is below 200.
- R5: `hsyncN` is low (active-low) exactly when `xPos` lies in [active width + front porch, that + 67). The front porch is 22 clocks, and the 67 clocks are about 4.7 us.
- R6: `vsyncN` is low (active-low) for exactly 3 lines. They start at line 232 in NTSC and at line 280 in PAL.
- R7: `eof` is high only in the cycle where both counters are at their last value. `sof` is high only when both counts are 0.
- R8: `palSel` (1 = PAL) is sampled only in the `eof` cycle. The new totals apply from the next frame's first clock, and changes at any other time have no effect.
- R9: With `HALF_RATE` = 1, line totals, active width, front porch and sync width are all halved (455/458 counts per line). Vertical timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| palSel | input | 1 | Standard request, 1 = PAL, taken at frame end |
| xPos | output | XW | Horizontal count |
| yPos | output | YW | Vertical line count |
| active | output | 1 | High inside the visible picture |
| hsyncN | output | 1 | Horizontal sync, active-low |
| vsyncN | output | 1 | Vertical sync, active-low |
| sof | output | 1 | High at count (0,0) |
| eof | output | 1 | High at the last count of the frame |

## Verification
The frame-end strobe coincides with both the line wrap and the moment the standard request is taken. A change of `palSel` made partway through a frame is therefore the case that must not leak into the running frame. The bench raises the request mid-frame and confirms that the following line still wraps at the NTSC total. It then checks that the next frame runs at the PAL line length with the PAL vertical sync position. Finally it drops the request partway through that PAL frame and confirms that the PAL frame still ends at its own last count.

// File: rtl/tvr_pkg.sv
package tvr_pkg;
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
    logic pal;
  } tvrStrobe_t;
endpackage

// File: rtl/tvr_ctrl.sv
module tvr_ctrl
  import tvr_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int H_N = 910,
  parameter int H_P = 916,
  parameter int V_N = 263,
  parameter int V_P = 312
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          palSel,
  input  logic [XW-1:0] xPos,
  input  logic [YW-1:0] yPos,
  output tvrStrobe_t    strobe
);
  logic palReg;
  logic [XW-1:0] hLast;
  logic [YW-1:0] vLast;
  logic lineEnd, frameEnd;

  always_comb begin
    hLast    = palReg ? XW'(H_P - 1) : XW'(H_N - 1);
    vLast    = palReg ? YW'(V_P - 1) : YW'(V_N - 1);
    lineEnd  = (xPos == hLast);
    frameEnd = lineEnd && (yPos == vLast);
    strobe.lineEnd  = lineEnd;
    strobe.frameEnd = frameEnd;
    strobe.pal      = palReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         palReg <= 1'b0;
    else if (frameEnd) palReg <= palSel;
  end
endmodule

// File: rtl/tvr_datapath.sv
module tvr_datapath
  import tvr_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int ACT_W = 640,
  parameter int HS_START = 662,
  parameter int HS_LEN = 67,
  parameter int ACT_H = 200,
  parameter int VS_N = 232,
  parameter int VS_P = 280,
  parameter int VS_LEN = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  tvrStrobe_t    strobe,
  output logic [XW-1:0] xPos,
  output logic [YW-1:0] yPos,
  output logic          active,
  output logic          hsyncN,
  output logic          vsyncN,
  output logic          sof
);
  int xInt, yInt, vsStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPos <= '0;
      yPos <= '0;
    end else begin
      xPos <= strobe.lineEnd ? '0 : xPos + 1'b1;
      if (strobe.frameEnd)     yPos <= '0;
      else if (strobe.lineEnd) yPos <= yPos + 1'b1;
    end
  end

  always_comb begin
    xInt    = int'(xPos);
    yInt    = int'(yPos);
    vsStart = strobe.pal ? VS_P : VS_N;
    active  = (xInt < ACT_W) && (yInt < ACT_H);
    hsyncN  = !((xInt >= HS_START) && (xInt < HS_START + HS_LEN));
    vsyncN  = !((yInt >= vsStart) && (yInt < vsStart + VS_LEN));
    sof     = (xPos == '0) && (yPos == '0);
  end
endmodule

// File: rtl/tv_raster_gen.sv
module tv_raster_gen
  import tvr_pkg::*;
#(
  parameter int HALF_RATE     = 0,
  parameter int NTSC_HTOTAL   = 910,
  parameter int PAL_HTOTAL    = 916,
  parameter int ACT_W         = 640,
  parameter int H_FRONT       = 22,
  parameter int HSYNC_LEN     = 67,
  parameter int NTSC_VTOTAL   = 263,
  parameter int PAL_VTOTAL    = 312,
  parameter int ACT_H         = 200,
  parameter int NTSC_VS_START = 232,
  parameter int PAL_VS_START  = 280,
  parameter int VS_LEN        = 3,
  localparam int DIV   = (HALF_RATE != 0) ? 2 : 1,
  localparam int H_N   = NTSC_HTOTAL / DIV,
  localparam int H_P   = PAL_HTOTAL / DIV,
  localparam int AW    = ACT_W / DIV,
  localparam int HS_ST = (ACT_W + H_FRONT) / DIV,
  localparam int HS_LN = HSYNC_LEN / DIV,
  localparam int XW    = $clog2((H_N > H_P) ? H_N : H_P),
  localparam int YW    = $clog2((NTSC_VTOTAL > PAL_VTOTAL) ? NTSC_VTOTAL : PAL_VTOTAL)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          palSel,
  output logic [XW-1:0] xPos,
  output logic [YW-1:0] yPos,
  output logic          active,
  output logic          hsyncN,
  output logic          vsyncN,
  output logic          sof,
  output logic          eof
);
  tvrStrobe_t ctrlBus;

  tvr_ctrl #(
    .XW(XW), .YW(YW), .H_N(H_N), .H_P(H_P),
    .V_N(NTSC_VTOTAL), .V_P(PAL_VTOTAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .palSel(palSel),
    .xPos(xPos), .yPos(yPos), .strobe(ctrlBus)
  );

  tvr_datapath #(
    .XW(XW), .YW(YW), .ACT_W(AW), .HS_START(HS_ST), .HS_LEN(HS_LN),
    .ACT_H(ACT_H), .VS_N(NTSC_VS_START), .VS_P(PAL_VS_START), .VS_LEN(VS_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(ctrlBus),
    .xPos(xPos), .yPos(yPos), .active(active),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .sof(sof)
  );

  assign eof = ctrlBus.frameEnd;
endmodule

// File: rtl/tvr_checker.sv
module tvr_checker #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int H_N = 910,
  parameter int H_P = 916
) (
  input logic          clk,
  input logic          rstN,
  input logic [XW-1:0] xPos,
  input logic [YW-1:0] yPos,
  input logic          active,
  input logic          hsyncN,
  input logic          vsyncN,
  input logic          sof,
  input logic          eof,
  input logic          curPal
);
  logic atLineEnd;
  assign atLineEnd = curPal ? (int'(xPos) == H_P - 1) : (int'(xPos) == H_N - 1);

  a_r2_x_step: assert property (@(posedge clk) disable iff (!rstN)
    !atLineEnd |=> (int'(xPos) == int'($past(xPos)) + 1));

  a_r3_y_hold: assert property (@(posedge clk) disable iff (!rstN)
    !atLineEnd |=> $stable(yPos));

  a_r7_eof_wraps: assert property (@(posedge clk) disable iff (!rstN)
    eof |=> (xPos == '0) && (yPos == '0));

  a_r7_sof_visible: assert property (@(posedge clk) disable iff (!rstN)
    sof |-> active);

  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    !eof |=> $stable(curPal));

  a_r5_hsync_blank: assert property (@(posedge clk) disable iff (!rstN)
    !hsyncN |-> !active);

  a_r6_vsync_blank: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncN |-> !active);
endmodule

bind tv_raster_gen tvr_checker #(.XW(XW), .YW(YW), .H_N(H_N), .H_P(H_P)) u_chk (
  .clk(clk), .rstN(rstN), .xPos(xPos), .yPos(yPos), .active(active),
  .hsyncN(hsyncN), .vsyncN(vsyncN), .sof(sof), .eof(eof), .curPal(ctrlBus.pal)
);

// File: tb/test_tv_raster_gen.sv
`timescale 1ns/1ps
module test_tv_raster_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic palSel = 1'b0;
  logic [5:0] xPos;
  logic [3:0] yPos;
  logic active, hsyncN, vsyncN, sof, eof;
  logic [4:0] x2;
  logic [3:0] y2;
  logic active2, hsyncN2, vsyncN2, sof2, eof2;
  int nChecks = 0;
  int nErrors = 0;
  bit halfDone = 1'b0;

  always #2 clk = ~clk;

  tv_raster_gen #(
    .HALF_RATE(0), .NTSC_HTOTAL(40), .PAL_HTOTAL(48), .ACT_W(20), .H_FRONT(4),
    .HSYNC_LEN(6), .NTSC_VTOTAL(12), .PAL_VTOTAL(15), .ACT_H(6),
    .NTSC_VS_START(8), .PAL_VS_START(10), .VS_LEN(3)
  ) i_tv_raster_gen (
    .clk(clk), .rstN(rstN), .palSel(palSel), .xPos(xPos), .yPos(yPos),
    .active(active), .hsyncN(hsyncN), .vsyncN(vsyncN), .sof(sof), .eof(eof)
  );

  tv_raster_gen #(
    .HALF_RATE(1), .NTSC_HTOTAL(40), .PAL_HTOTAL(48), .ACT_W(20), .H_FRONT(4),
    .HSYNC_LEN(6), .NTSC_VTOTAL(12), .PAL_VTOTAL(15), .ACT_H(6),
    .NTSC_VS_START(8), .PAL_VS_START(10), .VS_LEN(3)
  ) i_half (
    .clk(clk), .rstN(rstN), .palSel(1'b0), .xPos(x2), .yPos(y2),
    .active(active2), .hsyncN(hsyncN2), .vsyncN(vsyncN2), .sof(sof2), .eof(eof2)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int c, int x, int y, logic [4:0] f);
    logic [11:0] cc = c[11:0];
    logic [5:0]  xx = x[5:0];
    logic [3:0]  yy = y[3:0];
    return {cc, xx, yy, 5'b0, f};
  endfunction

  // flags: {sof, eof, active, hsyncN, vsyncN}; cycle = y*40 + x in NTSC
  localparam logic [31:0] VEC [16] = '{
    mk(0,   0,  0,  5'b10111), mk(19,  19, 0,  5'b00111),
    mk(20,  20, 0,  5'b00011), mk(23,  23, 0,  5'b00011),
    mk(24,  24, 0,  5'b00001), mk(29,  29, 0,  5'b00001),
    mk(30,  30, 0,  5'b00011), mk(39,  39, 0,  5'b00011),
    mk(40,  0,  1,  5'b00111), mk(205, 5,  5,  5'b00111),
    mk(245, 5,  6,  5'b00011), mk(320, 0,  8,  5'b00010),
    mk(425, 25, 10, 5'b00000), mk(440, 0,  11, 5'b00011),
    mk(479, 39, 11, 5'b01011), mk(480, 0,  0,  5'b10111)
  };

  int cur = 0;

  task automatic stepTo(input int target);
    repeat (target - cur) @(negedge clk);
    cur = target;
  endtask

  // half-rate instance: line of 20, active 10, hsync [12,15)
  initial begin
    @(posedge rstN);
    for (int n = 1; n <= 239; n++) begin
      @(negedge clk);
      if (n == 9)  chk("R9 half active", int'(active2), 1);
      if (n == 10) chk("R9 half active end", int'(active2), 0);
      if (n == 12) chk("R9 half hsync start", int'(hsyncN2), 0);
      if (n == 15) chk("R9 half hsync end", int'(hsyncN2), 1);
      if (n == 19) chk("R9 half x last", int'(x2), 19);
      if (n == 20) begin
        chk("R9 half x wrap", int'(x2), 0);
        chk("R9 half y step", int'(y2), 1);
      end
      if (n == 239) chk("R9 half eof", int'(eof2), 1);
    end
    halfDone = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset x", int'(xPos), 0);
    chk("R1 reset y", int'(yPos), 0);
    chk("R1 reset sof", int'(sof), 1);
    rstN = 1'b1;

    for (int i = 0; i < 16; i++) begin
      logic [31:0] v = VEC[i];
      stepTo(int'(v[31:20]));
      chk("R2 x", int'(xPos), int'(v[19:14]));
      chk("R3 y", int'(yPos), int'(v[13:10]));
      chk("R7 sof", int'(sof), int'(v[4]));
      chk("R7 eof", int'(eof), int'(v[3]));
      chk("R4 active", int'(active), int'(v[2]));
      chk("R5 hsyncN", int'(hsyncN), int'(v[1]));
      chk("R6 vsyncN", int'(vsyncN), int'(v[0]));
    end

    // R8: request PAL mid-frame; current frame keeps NTSC totals
    stepTo(500); palSel = 1'b1;
    stepTo(559); chk("R8 ntsc kept x", int'(xPos), 39);
    stepTo(560);
    chk("R8 ntsc kept wrap x", int'(xPos), 0);
    chk("R8 ntsc kept wrap y", int'(yPos), 2);
    stepTo(959); chk("R8 ntsc eof", int'(eof), 1);
    stepTo(960); chk("R7 sof pal frame", int'(sof), 1);
    stepTo(999); chk("R2 pal no wrap at 40", int'(xPos), 39);
    stepTo(1007); chk("R2 pal x last", int'(xPos), 47);
    stepTo(1008);
    chk("R2 pal wrap x", int'(xPos), 0);
    chk("R3 pal y", int'(yPos), 1);
    stepTo(1010); palSel = 1'b0;
    stepTo(1344); chk("R6 pal no vsync at line 8", int'(vsyncN), 1);
    stepTo(1440); chk("R6 pal vsync at line 10", int'(vsyncN), 0);
    stepTo(1679);
    chk("R8 pal frame kept eof", int'(eof), 1);
    chk("R3 pal last line", int'(yPos), 14);
    stepTo(1720);
    chk("R8 ntsc back x", int'(xPos), 0);
    chk("R8 ntsc back y", int'(yPos), 1);

    stepTo(1750);
    #1 rstN = 1'b0;
    #1;
    chk("R1 async reset x", int'(xPos), 0);
    chk("R1 async reset y", int'(yPos), 0);

    wait (halfDone);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule